// File: doc/BRIEF.md
# Register Hazard Tracker for In-Order Issue

This block sits at the issue point of an in-order pipeline and blocks any instruction that would read a register whose newest value has not yet been written back. It covers one flat index space of 64 registers, shared by the general-purpose and special registers. Each issued instruction that produces a register result receives a 2-bit tag. The block keeps, for each register, whether a write is pending and which tag will perform it.

A reader of a pending register is held until the writeback port reports that register's recorded tag. There is no operand forwarding, so a source becomes usable in the cycle its value reaches the register file. The register file is assumed to write through, so the hazard clears in the same cycle as the matching writeback. At most one writeback completes per cycle. Tags are handed out round-robin, and a writer is held when the next tag still belongs to an instruction that has not completed.

Top module: `hz_tracker`

## Requirements
- R1: When an instruction that writes a register issues, `tag_o` shows the tag it is given. Tags are given in the order 0, 1, 2, 3 and then wrap to 0.
- R2: An instruction that issues with `iss_wr_i` low takes no tag, and `tag_o` does not change.
- R3: An instruction stalls if any enabled source (slot k uses bits [6k+5:6k] of `iss_src_i`, enabled by `iss_src_en_i[k]`) names a register with a pending write.
- R4: The stall lasts until writeback reports the tag recorded for that register. In that same cycle `stall_o` drops, and afterwards the register is no longer pending.
- R5: A newer writer to a register replaces the recorded tag. A writeback carrying the older tag leaves the register pending.
- R6: A register-writing instruction stalls while the next tag to be given is still outstanding. A writeback of that tag in the same cycle lets it issue.
- R7: Sources whose enable bit is low have no effect on the stall.
- R8: All 64 register indices, 0 to 63, are tracked independently.
- R9: A writeback whose tag matches no record leaves every pending register pending.
- R10: Synchronous active-high reset clears every pending record and every tag in use. After reset, `tag_o` is 0.
- R11: `stall_o` is low whenever `iss_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | An instruction is presented for issue |
| iss_wr_i | input | 1 | The instruction writes a destination register |
| iss_dst_i | input | 6 | Destination register index |
| iss_src_en_i | input | 3 | Per-slot source enables |
| iss_src_i | input | 18 | Three source indices, slot k in bits [6k+5:6k] |
| wb_valid_i | input | 1 | A writeback completes this cycle |
| wb_tag_i | input | 2 | Tag of the completing instruction |
| stall_o | output | 1 | The presented instruction cannot issue this cycle |
| tag_o | output | 2 | Tag given to the presented writer if it issues |

## Verification
The hardest case to reach is a register that is pending under one tag while a writeback arrives for a different tag that was once recorded for it. This happens only when two writers to the same register are both outstanding. The bench issues two back-to-back writes to one index before any writeback, then reads that index while completing the older tag, and only then the newer one. Tag exhaustion is another hard case. The bench reaches it by issuing four writers with no writebacks, and then checks both the stalled fifth writer and the same-cycle release when tag 0 completes.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int unsigned REG_COUNT = 64;
    parameter int unsigned TAG_BITS  = 2;
    parameter int unsigned SRC_PORTS = 3;

    localparam int unsigned IDX_BITS  = $clog2(REG_COUNT);
    localparam int unsigned TAG_COUNT = 1 << TAG_BITS;

    typedef logic [IDX_BITS-1:0] reg_idx_t;
    typedef logic [TAG_BITS-1:0] tag_t;

    typedef struct packed {
        logic pending;
        tag_t tag;
    } reg_rec_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } wb_rpt_t;

    function automatic logic tag_retiring(wb_rpt_t wb, tag_t t);
        return wb.valid && (wb.tag == t);
    endfunction
endpackage

// File: rtl/hz_tag_pool.sv
module hz_tag_pool
    import hz_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    alloc_i,
    input  wb_rpt_t wb_i,
    output tag_t    next_tag_o,
    output logic    next_blocked_o
);
    logic [TAG_COUNT-1:0] busy_q;
    tag_t                 ptr_q;

    assign next_tag_o     = ptr_q;
    assign next_blocked_o = busy_q[ptr_q] && !tag_retiring(wb_i, ptr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (wb_i.valid) busy_q[wb_i.tag] <= 1'b0;
            if (alloc_i) begin
                busy_q[ptr_q] <= 1'b1;
                ptr_q         <= ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
    import hz_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  reg_idx_t                  wr_idx_i,
    input  tag_t                      wr_tag_i,
    input  wb_rpt_t                   wb_i,
    output reg_rec_t [REG_COUNT-1:0]  rec_o
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_entry
        reg_rec_t rec_q;
        assign rec_o[g] = rec_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rec_q <= '0;
            end else if (wr_en_i && (wr_idx_i == reg_idx_t'(g))) begin
                rec_q.pending <= 1'b1;
                rec_q.tag     <= wr_tag_i;
            end else if (rec_q.pending && tag_retiring(wb_i, rec_q.tag)) begin
                rec_q.pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
    import hz_pkg::*;
(
    input  reg_rec_t [REG_COUNT-1:0]           rec_i,
    input  logic [SRC_PORTS-1:0]               src_en_i,
    input  logic [SRC_PORTS*IDX_BITS-1:0]      src_i,
    input  wb_rpt_t                            wb_i,
    output logic                               hazard_o
);
    logic [SRC_PORTS-1:0] hit;

    for (genvar k = 0; k < SRC_PORTS; k++) begin : g_slot
        reg_idx_t idx;
        reg_rec_t rec;
        assign idx    = src_i[k*IDX_BITS +: IDX_BITS];
        assign rec    = rec_i[idx];
        assign hit[k] = src_en_i[k] && rec.pending && !tag_retiring(wb_i, rec.tag);
    end

    assign hazard_o = |hit;
endmodule

// File: rtl/hz_tracker.sv
module hz_tracker
    import hz_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          iss_valid_i,
    input  logic                          iss_wr_i,
    input  logic [IDX_BITS-1:0]           iss_dst_i,
    input  logic [SRC_PORTS-1:0]          iss_src_en_i,
    input  logic [SRC_PORTS*IDX_BITS-1:0] iss_src_i,
    input  logic                          wb_valid_i,
    input  logic [TAG_BITS-1:0]           wb_tag_i,
    output logic                          stall_o,
    output logic [TAG_BITS-1:0]           tag_o
);
    wb_rpt_t                  wb;
    reg_rec_t [REG_COUNT-1:0] recs;
    tag_t                     next_tag;
    logic                     tag_blocked;
    logic                     src_hazard;
    logic                     alloc;

    assign wb.valid = wb_valid_i;
    assign wb.tag   = wb_tag_i;

    assign stall_o = iss_valid_i && (src_hazard || (iss_wr_i && tag_blocked));
    assign alloc   = iss_valid_i && iss_wr_i && !stall_o;
    assign tag_o   = next_tag;

    hz_tag_pool u_pool (
        .clk            (clk),
        .rst            (rst),
        .alloc_i        (alloc),
        .wb_i           (wb),
        .next_tag_o     (next_tag),
        .next_blocked_o (tag_blocked)
    );

    hz_scoreboard u_board (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (alloc),
        .wr_idx_i (iss_dst_i),
        .wr_tag_i (next_tag),
        .wb_i     (wb),
        .rec_o    (recs)
    );

    hz_src_check u_check (
        .rec_i    (recs),
        .src_en_i (iss_src_en_i),
        .src_i    (iss_src_i),
        .wb_i     (wb),
        .hazard_o (src_hazard)
    );
endmodule

// File: rtl/hz_tracker_chk.sv
module hz_tracker_chk
    import hz_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          iss_valid_i,
    input logic                          iss_wr_i,
    input logic [IDX_BITS-1:0]           iss_dst_i,
    input logic [SRC_PORTS-1:0]          iss_src_en_i,
    input logic [SRC_PORTS*IDX_BITS-1:0] iss_src_i,
    input logic                          wb_valid_i,
    input logic                          stall_o,
    input logic [TAG_BITS-1:0]           tag_o
);
    logic fire_wr;
    assign fire_wr = iss_valid_i && iss_wr_i && !stall_o;

    p_tag_step_r1: assert property (@(posedge clk) disable iff (rst)
        fire_wr |=> tag_o == tag_t'($past(tag_o) + 1'b1));

    p_tag_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !fire_wr |=> $stable(tag_o));

    p_raw_stall_r3: assert property (@(posedge clk) disable iff (rst)
        fire_wr ##1 (iss_valid_i && iss_src_en_i[0] && !wb_valid_i &&
                     iss_src_i[IDX_BITS-1:0] == $past(iss_dst_i)) |-> stall_o);

    p_reset_tag_r10: assert property (@(posedge clk)
        rst |=> tag_o == '0);

    p_idle_nostall_r11: assert property (@(posedge clk) disable iff (rst)
        !iss_valid_i |-> !stall_o);
endmodule

bind hz_tracker hz_tracker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .iss_valid_i  (iss_valid_i),
    .iss_wr_i     (iss_wr_i),
    .iss_dst_i    (iss_dst_i),
    .iss_src_en_i (iss_src_en_i),
    .iss_src_i    (iss_src_i),
    .wb_valid_i   (wb_valid_i),
    .stall_o      (stall_o),
    .tag_o        (tag_o)
);

// File: tb/hz_tracker_bench.sv
module hz_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid_i = 1'b0;
    logic        iss_wr_i = 1'b0;
    logic [5:0]  iss_dst_i = '0;
    logic [2:0]  iss_src_en_i = '0;
    logic [17:0] iss_src_i = '0;
    logic        wb_valid_i = 1'b0;
    logic [1:0]  wb_tag_i = '0;
    logic        stall_o;
    logic [1:0]  tag_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    hz_tracker u_hz_tracker (
        .clk(clk), .rst(rst), .iss_valid_i(iss_valid_i), .iss_wr_i(iss_wr_i),
        .iss_dst_i(iss_dst_i), .iss_src_en_i(iss_src_en_i), .iss_src_i(iss_src_i),
        .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .stall_o(stall_o), .tag_o(tag_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(bit v, bit wr, int dst, bit [2:0] en, int s0, int s1, int s2,
                         bit wv, int wt);
        iss_valid_i  = v;
        iss_wr_i     = wr;
        iss_dst_i    = 6'(dst);
        iss_src_en_i = en;
        iss_src_i    = {6'(s2), 6'(s1), 6'(s0)};
        wb_valid_i   = wv;
        wb_tag_i     = 2'(wt);
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        drive(0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
        chk("R10 tag after reset", tag_o, 0);
        chk("R11 idle no stall", stall_o, 0);
        drive(1, 1, 30, 3'b000, 0, 0, 0, 0, 0); step();
        drive(0, 0, 0, 3'b001, 30, 0, 0, 0, 0);
        chk("R11 invalid reader of pending reg", stall_o, 0);
        do_reset();
        drive(1, 0, 0, 3'b001, 30, 0, 0, 0, 0);
        chk("R10 record cleared", stall_o, 0);
        chk("R10 tag cleared", tag_o, 0);
    endtask

    task automatic t_round_robin();
        do_reset();
        drive(1, 1, 5, 3'b000, 0, 0, 0, 0, 0);
        chk("R1 first tag", tag_o, 0);
        chk("R1 no stall", stall_o, 0);
        step();
        drive(1, 1, 6, 3'b000, 0, 0, 0, 0, 0);
        chk("R1 second tag", tag_o, 1);
        step();
        drive(1, 0, 0, 3'b000, 0, 0, 0, 0, 0);
        chk("R2 non-writer issues", stall_o, 0);
        step();
        drive(1, 1, 7, 3'b000, 0, 0, 0, 0, 0);
        chk("R2 tag unchanged", tag_o, 2);
        step();
        drive(1, 1, 8, 3'b000, 0, 0, 0, 0, 0);
        chk("R1 fourth tag", tag_o, 3);
        step();
        drive(1, 1, 9, 3'b000, 0, 0, 0, 0, 0);
        chk("R6 tags exhausted stall", stall_o, 1);
        chk("R1 wrapped tag", tag_o, 0);
        step();
        drive(1, 1, 9, 3'b000, 0, 0, 0, 1, 0);
        chk("R6 same-cycle release", stall_o, 0);
        step();
        drive(0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
        chk("R1 tag after wrap issue", tag_o, 1);
        drive(1, 0, 0, 3'b001, 9, 0, 0, 0, 0);
        chk("R3 reader of reused tag record", stall_o, 1);
        drive(1, 0, 0, 3'b001, 5, 0, 0, 0, 0);
        chk("R4 register freed by wb", stall_o, 0);
    endtask

    task automatic t_raw();
        do_reset();
        drive(1, 1, 10, 3'b000, 0, 0, 0, 0, 0); step();
        drive(1, 0, 0, 3'b001, 10, 0, 0, 0, 0);
        chk("R3 read pending", stall_o, 1);
        step();
        drive(1, 0, 0, 3'b001, 10, 0, 0, 0, 0);
        chk("R4 still waiting", stall_o, 1);
        step();
        drive(1, 0, 0, 3'b001, 10, 0, 0, 1, 0);
        chk("R4 released on matching wb", stall_o, 0);
        step();
        drive(1, 0, 0, 3'b001, 10, 0, 0, 0, 0);
        chk("R4 record cleared", stall_o, 0);
    endtask

    task automatic t_waw();
        do_reset();
        drive(1, 1, 12, 3'b000, 0, 0, 0, 0, 0); step();
        drive(1, 1, 12, 3'b000, 0, 0, 0, 0, 0); step();
        drive(1, 0, 0, 3'b001, 12, 0, 0, 1, 0);
        chk("R5 older wb does not release", stall_o, 1);
        step();
        drive(1, 0, 0, 3'b001, 12, 0, 0, 0, 0);
        chk("R5 record kept after older wb", stall_o, 1);
        drive(1, 0, 0, 3'b001, 12, 0, 0, 1, 1);
        chk("R5 newer wb releases", stall_o, 0);
        step();
        drive(1, 0, 0, 3'b001, 12, 0, 0, 0, 0);
        chk("R5 cleared", stall_o, 0);
    endtask

    task automatic t_src_mask();
        do_reset();
        drive(1, 1, 20, 3'b000, 0, 0, 0, 0, 0); step();
        drive(1, 0, 0, 3'b000, 20, 20, 20, 0, 0);
        chk("R7 all slots disabled", stall_o, 0);
        drive(1, 0, 0, 3'b010, 0, 20, 0, 0, 0);
        chk("R3 slot 1", stall_o, 1);
        drive(1, 0, 0, 3'b100, 0, 0, 20, 0, 0);
        chk("R3 slot 2", stall_o, 1);
        drive(1, 0, 0, 3'b011, 21, 22, 20, 0, 0);
        chk("R7 disabled slot 2 ignored", stall_o, 0);
    endtask

    task automatic t_index();
        do_reset();
        drive(1, 1, 63, 3'b000, 0, 0, 0, 0, 0); step();
        drive(1, 0, 0, 3'b001, 0, 0, 0, 0, 0);
        chk("R8 index 0 independent", stall_o, 0);
        drive(1, 0, 0, 3'b001, 63, 0, 0, 0, 0);
        chk("R8 index 63 pending", stall_o, 1);
        drive(1, 0, 0, 3'b001, 63, 0, 0, 1, 1);
        chk("R9 unmatched wb", stall_o, 1);
        step();
        drive(1, 0, 0, 3'b001, 63, 0, 0, 0, 0);
        chk("R9 still pending after unmatched wb", stall_o, 1);
        drive(1, 0, 0, 3'b001, 63, 0, 0, 1, 0);
        chk("R4 index 63 released", stall_o, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_raw();
        t_waw();
        t_src_mask();
        t_index();
        finish_run();
    end
endmodule